// File: doc/BRIEF.md
# Reloadable 8-bit PWM Timer Channel

This block is a single PWM and timer channel. An 8-bit up-counter advances on ticks from a 16-bit programmable prescaler. The prescaler is fed either by the system clock or by rising edges of an external clock pin. Each counting cycle begins at a programmable reload value, so the reload value sets the period. A compare value sets the point where the output drops from high to low. Software programs three values through a small write port, picks the tick source, and starts or stops the channel. While the channel is stopped, its output enable is low, so the pad floats.

The channel is controlled by a two-state machine. ST_IDLE is the stopped state, with the output disabled and the counter and prescaler frozen. ST_RUN drives the output. The transition START (ST_IDLE to ST_RUN) is taken when start is high and stop is low. It loads the counter with the reload value, copies the pending compare value into the active compare register and clears the prescaler. The transition HALT (ST_RUN to ST_IDLE) is taken on stop. The transition WRAP (ST_RUN to ST_RUN) is taken on a tick when the counter is at 254 or above. WRAP reloads the counter and moves the pending compare value into the active one. The compare value is double-buffered in this way, but a new reload value acts at once.

Top module: `pwm_reload_timer`

## Requirements
- R1: While rst_n is low, and whenever the channel is stopped, pwm_oe and pwm_out are both 0.
- R2: A start pulse (start=1, stop=0) while stopped sets pwm_oe to 1 from the next cycle. It begins a counting cycle at the reload value with the prescaler cleared. When start and stop are both high, stop takes priority.
- R3: A stop pulse while running brings pwm_oe and pwm_out to 0 on the next cycle. While stopped, no prescaler ticks occur and the counter holds its value.
- R4: A counting cycle lasts (255 - reload) prescaler ticks, and reload values of 254 and 255 both give a one-tick cycle. The counter goes back to the reload value automatically at the end of each cycle.
- R5: Within a cycle, pwm_out is high from its start until the counter equals the compare value, then low until the next cycle. The high time is (compare - reload) ticks.
- R6: A compare value of 255 keeps pwm_out permanently high while running.
- R7: A compare value of 0, or one below the reload value, keeps pwm_out permanently low while running.
- R8: Writing wr_sel=1 stores wr_data[7:0] as the pending compare value. The active compare changes only at the end of the current cycle or at start.
- R9: Writing wr_sel=0 stores wr_data[7:0] as the reload value. It affects the output comparison in the cycle right after the write, even mid-cycle.
- R10: Writing wr_sel=2 stores wr_data[15:0] as the prescale value N. One tick is produced every N source events, and N=0 behaves as N=1.
- R11: With clk_sel=1, source events are rising edges of ext_clk after a two-flop synchroniser. With clk_sel=0, every system clock cycle is a source event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 reload, 1 compare, 2 prescale |
| wr_data | input | 16 | Write data |
| clk_sel | input | 1 | Tick source: 0 system clock, 1 external pin |
| ext_clk | input | 1 | External clock pin, asynchronous |
| start | input | 1 | Start request |
| stop | input | 1 | Stop request, dominant over start |
| pwm_out | output | 1 | PWM output level |
| pwm_oe | output | 1 | Output enable; low leaves the pad floating |

## Verification
The hardest situations to reach are the ones where a write lands in the middle of a running cycle. A compare write must leave the rest of that cycle untouched and only alter the following one. A reload write must change the output right away. The stimulus starts the channel at a known cycle boundary and counts cycles from there. It places the write at a fixed offset inside the cycle, then checks every cycle of the remainder and of the next period against a formula-based expected waveform. Random trials cover reload, compare and prescale values, including the saturating compare values. A free-running external clock checks the synchronised tick path by measuring whole high and low run lengths.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } chan_state_e;

    typedef enum logic [1:0] {
        SEL_RELOAD   = 2'd0,
        SEL_COMPARE  = 2'd1,
        SEL_PRESCALE = 2'd2,
        SEL_NONE     = 2'd3
    } wr_sel_e;

endpackage

// File: rtl/pwm_ext_edge.sv
module pwm_ext_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic             src_en_i,
    input  logic [PSC_W-1:0] div_i,
    output logic             tick_o
);

    logic [PSC_W-1:0] pcnt_q;
    logic [PSC_W-1:0] limit;

    // Division by zero acts as division by one
    assign limit  = (div_i == '0) ? '0 : div_i - 1'b1;
    assign tick_o = run_i && src_en_i && (pcnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (clr_i) begin
            pcnt_q <= '0;
        end else if (run_i && src_en_i) begin
            pcnt_q <= tick_o ? '0 : pcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [CNT_W-1:0] cmp_pend_i,
    output logic             go_o,
    output logic             running_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_act_o,
    output logic             pwm_out_o,
    output logic             pwm_oe_o
);

    localparam logic [CNT_W-1:0] TOP_V  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] WRAP_V = TOP_V - 1'b1;

    chan_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic             wrap;
    logic             force_hi;
    logic             force_lo;

    assign go_o = (state_q == ST_IDLE) && start_i && !stop_i;
    assign wrap = tick_i && (cnt_q >= WRAP_V);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i && !stop_i) state_d = ST_RUN;   // START
            ST_RUN:  if (stop_i)             state_d = ST_IDLE;  // HALT
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Counter and active compare
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '0;
        end else if (go_o) begin
            cnt_q <= reload_i;
            cmp_q <= cmp_pend_i;
        end else if (state_q == ST_RUN && !stop_i && tick_i) begin
            if (wrap) begin                                       // WRAP
                cnt_q <= reload_i;
                cmp_q <= cmp_pend_i;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign force_hi = (cmp_q == TOP_V);
    assign force_lo = (cmp_q == '0) || (cmp_q < reload_i);

    // Outputs
    always_comb begin
        pwm_oe_o  = 1'b0;
        pwm_out_o = 1'b0;
        running_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                pwm_oe_o  = 1'b0;
                pwm_out_o = 1'b0;
            end
            ST_RUN: begin
                running_o = 1'b1;
                pwm_oe_o  = 1'b1;
                pwm_out_o = force_hi || (!force_lo && (cnt_q < cmp_q));
            end
            default: ;
        endcase
    end

    assign cnt_o     = cnt_q;
    assign cmp_act_o = cmp_q;

endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int PSC_W     = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [PSC_W-1:0] wr_data,
    input  logic             clk_sel,
    input  logic             ext_clk,
    input  logic             start,
    input  logic             stop,
    output logic             pwm_out,
    output logic             pwm_oe
);

    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cmp_pend_q;
    logic [PSC_W-1:0] psc_q;
    logic             ext_rise;
    logic             src_en;
    logic             psc_tick;
    logic             go;
    logic             running;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] cmp_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q   <= '0;
            cmp_pend_q <= '0;
            psc_q      <= '0;
        end else if (wr_en) begin
            case (wr_sel_e'(wr_sel))
                SEL_RELOAD:   reload_q   <= wr_data[CNT_W-1:0];
                SEL_COMPARE:  cmp_pend_q <= wr_data[CNT_W-1:0];
                SEL_PRESCALE: psc_q      <= wr_data;
                default: ;
            endcase
        end
    end

    pwm_ext_edge #(.STAGES(SYNC_STGS)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_clk),
        .rise_o (ext_rise)
    );

    assign src_en = clk_sel ? ext_rise : 1'b1;

    pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (running),
        .clr_i    (go),
        .src_en_i (src_en),
        .div_i    (psc_q),
        .tick_o   (psc_tick)
    );

    pwm_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .stop_i     (stop),
        .tick_i     (psc_tick),
        .reload_i   (reload_q),
        .cmp_pend_i (cmp_pend_q),
        .go_o       (go),
        .running_o  (running),
        .cnt_o      (cnt_val),
        .cmp_act_o  (cmp_act),
        .pwm_out_o  (pwm_out),
        .pwm_oe_o   (pwm_oe)
    );

endmodule

// File: rtl/pwm_reload_timer_chk.sv
module pwm_reload_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             stop,
    input logic             pwm_out,
    input logic             pwm_oe,
    input logic             psc_tick,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] cmp_act,
    input logic [CNT_W-1:0] reload_q
);

    localparam logic [CNT_W-1:0] TOP_V  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] WRAP_V = TOP_V - 1'b1;

    AST_OE_GATES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_oe |-> !pwm_out);                                              // R1

    AST_START_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_oe && start && !stop) |=> pwm_oe);                            // R2

    AST_STOP_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !pwm_oe);                                                  // R3

    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_oe |-> !psc_tick);                                             // R3

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_oe && !(start && !stop)) |=> $stable(cnt_val));               // R3

    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_oe && cmp_act == TOP_V) |-> pwm_out);                          // R6

    AST_FORCED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_oe && cmp_act != TOP_V && (cmp_act == '0 || cmp_act < reload_q))
        |-> !pwm_out);                                                      // R7

    AST_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_oe && !(psc_tick && cnt_val >= WRAP_V))
        |=> (!pwm_oe || $stable(cmp_act)));                                 // R8

endmodule

bind pwm_reload_timer pwm_reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .stop     (stop),
    .pwm_out  (pwm_out),
    .pwm_oe   (pwm_oe),
    .psc_tick (psc_tick),
    .cnt_val  (cnt_val),
    .cmp_act  (cmp_act),
    .reload_q (reload_q)
);

// File: tb/test_pwm_reload_timer.sv
module test_pwm_reload_timer;

    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        clk_sel = 1'b0;
    logic        ext_clk = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        pwm_out;
    logic        pwm_oe;

    int checks = 0;
    int errors = 0;

    pwm_reload_timer i_pwm_reload_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .clk_sel (clk_sel),
        .ext_clk (ext_clk),
        .start   (start),
        .stop    (stop),
        .pwm_out (pwm_out),
        .pwm_oe  (pwm_oe)
    );

    always #(CLK_P/2) clk = ~clk;

    // External clock: one rising edge every 8 system cycles
    initial forever begin
        #(CLK_P*4) ext_clk = ~ext_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P*150000);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    function automatic int period_len(int r, int n);
        return (r >= 254) ? n : (255 - r) * n;
    endfunction

    function automatic bit exp_level(int r, int c, int n, int i);
        if (c == 255) return 1'b1;
        if (c == 0 || c < r) return 1'b0;
        return (i < (c - r) * n);
    endfunction

    task automatic wr(input logic [1:0] sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    // Returns at the negedge right after the START edge
    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic check_period(input int r, input int c, input int n, input string req);
        int p = period_len(r, n);
        int bad = 0;
        int first_act = 0;
        int first_exp = 0;
        for (int i = 0; i < p; i++) begin
            if (pwm_out !== exp_level(r, c, n, i) || pwm_oe !== 1'b1) begin
                if (bad == 0) begin
                    first_act = int'(pwm_out);
                    first_exp = int'(exp_level(r, c, n, i));
                end
                bad++;
            end
            @(negedge clk);
        end
        chk(bad == 0, req, first_act, first_exp);
    endtask

    task automatic setup(input int r, input int c, input int psc);
        do_stop();
        wr(2'd0, r);
        wr(2'd1, c);
        wr(2'd2, psc);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4321);

        // R1: reset state
        #(CLK_P*3);
        @(negedge clk);
        chk(pwm_oe === 1'b0 && pwm_out === 1'b0, "R1 in reset", int'(pwm_oe), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(pwm_oe === 1'b0 && pwm_out === 1'b0, "R1 after reset", int'(pwm_oe), 0);

        // R2 R4 R5: basic cycle, divide by 1
        setup(0, 100, 1);
        do_start();
        chk(pwm_oe === 1'b1, "R2 start enables", int'(pwm_oe), 1);
        check_period(0, 100, 1, "R5 first period");
        check_period(0, 100, 1, "R4 automatic reload");

        // R3: stop disables and holds low
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        chk(pwm_oe === 1'b0 && pwm_out === 1'b0, "R3 stop", int'(pwm_oe), 0);
        repeat (40) @(negedge clk);
        chk(pwm_oe === 1'b0 && pwm_out === 1'b0, "R1 stopped stays off", int'(pwm_out), 0);

        // R2: stop dominates start
        @(negedge clk); start = 1'b1; stop = 1'b1;
        @(negedge clk); start = 1'b0; stop = 1'b0;
        chk(pwm_oe === 1'b0, "R2 stop wins over start", int'(pwm_oe), 0);

        // R10: prescale 0 acts as 1; prescale 5
        setup(200, 230, 0);
        do_start();
        check_period(200, 230, 1, "R10 prescale zero");
        setup(250, 252, 5);
        do_start();
        check_period(250, 252, 5, "R10 prescale five");
        check_period(250, 252, 5, "R10 prescale five second");

        // R6 R7: saturating compare values
        setup(100, 255, 2);
        do_start();
        check_period(100, 255, 2, "R6 compare 255");
        setup(100, 0, 1);
        do_start();
        check_period(100, 0, 1, "R7 compare zero");
        setup(120, 60, 1);
        do_start();
        check_period(120, 60, 1, "R7 compare below reload");

        // R4: reload at the top gives one-tick cycles
        setup(255, 255, 3);
        do_start();
        check_period(255, 255, 3, "R4 reload 255");

        // R8: compare write mid-cycle waits for the wrap
        setup(0, 50, 1);
        do_start();
        begin
            int highs = 0;
            for (int i = 0; i < 255; i++) begin
                if (i == 10) begin wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd200; end
                if (i == 11) wr_en = 1'b0;
                if (pwm_out === 1'b1) highs++;
                @(negedge clk);
            end
            chk(highs == 50, "R8 old compare kept this cycle", highs, 50);
        end
        check_period(0, 200, 1, "R8 new compare next cycle");

        // R9: reload write acts at once
        setup(0, 100, 1);
        do_start();
        repeat (20) @(negedge clk);
        chk(pwm_out === 1'b1, "R9 high before reload write", int'(pwm_out), 1);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'd150;
        @(negedge clk);
        wr_en = 1'b0;
        chk(pwm_out === 1'b0, "R9 reload above compare forces low", int'(pwm_out), 0);

        // R11: external clock, one tick per 8 system cycles
        clk_sel = 1'b1;
        setup(240, 245, 1);
        do_start();
        begin
            int guard = 0;
            int hl = 0;
            int ll = 0;
            while (pwm_out === 1'b1 && guard < 2000) begin guard++; @(negedge clk); end
            while (pwm_out === 1'b0 && guard < 2000) begin guard++; ll++; @(negedge clk); end
            while (pwm_out === 1'b1 && guard < 2000) begin guard++; hl++; @(negedge clk); end
            chk(hl == 40, "R11 external high run", hl, 40);
            chk(ll == 80, "R11 external low run", ll, 80);
        end
        clk_sel = 1'b0;

        // R5 R6 R7 R10: random trials
        for (int t = 0; t < 16; t++) begin
            int r = int'($urandom % 256);
            int c = int'($urandom % 256);
            int n = 1 + int'($urandom % 3);
            if (t % 5 == 1) c = 255;
            if (t % 5 == 2) c = 0;
            setup(r, c, n);
            do_start();
            check_period(r, c, n, "R5 random period");
            check_period(r, c, n, "R4 random repeat");
        end

        do_stop();
        finish_run();
    end

endmodule